// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block sits beside a small processor core and decides which of five interrupt sources the core should serve next. The sources are, in index order, external line 0, timer 0, external line 1, timer 1 and the serial channel. Software programs two registers through a simple write strobe. The mask register carries one enable bit per source plus a master enable in its top bit. The level register marks each source as high or low priority.

At each instruction boundary that the core signals, the arbiter looks at the pending, unmasked requests. It keeps one in-service flag per priority level, and these flags decide which requests may interrupt the current handler. A request that wins produces, one clock later, a one-cycle grant with a one-hot acknowledge naming the source. In the same cycle it gives a fixed 16-bit handler address: 0x0003 plus eight times the source index. The core pulses a return strobe when a handler finishes. That strobe releases the highest level currently in service.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the mask register and the level register are all zero. With every request line high and the boundary input high, no grant is produced.
- R2: Bit 7 of the mask register is the master enable. While it is 0, no request is granted, whatever the per-source bits hold.
- R3: Mask register bit i (0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial) enables source i. A pending request from a source whose bit is 0 is never granted.
- R4: The handler address for a grant of source i is 0x0003 + 8*i. That gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R5: A request is granted only in a cycle where `boundary_i` is 1. The grant appears one clock later as a one-cycle `take_o` pulse, with exactly one bit of `ack_o` set to the source index. While `take_o` is 0, `ack_o` is 0.
- R6: Among eligible requests of the same level, the lowest source index wins.
- R7: When eligible high and low requests are pending together, the lowest-indexed high request wins.
- R8: While a low-level handler is in service and no high-level one is, a low request is not granted. A high request is granted and preempts it.
- R9: While a high-level handler is in service, no request of either level is granted.
- R10: A cycle with `reti_i` high clears the high in-service flag if it is set, and otherwise the low one. With both levels in service, one return leaves the low level still blocking low requests.
- R11: Level register bit i (same source mapping as R3) set to 1 makes source i high priority. Set to 0, it makes source i low priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mask_we_i | input | 1 | Write strobe for the mask register |
| level_we_i | input | 1 | Write strobe for the level register |
| cfg_wdata_i | input | 8 | Write data for either register |
| req_i | input | 5 | Pending request per source, index order as in R3 |
| boundary_i | input | 1 | Core is at an instruction boundary and may take an interrupt |
| reti_i | input | 1 | Handler return strobe |
| take_o | output | 1 | One-cycle grant pulse |
| ack_o | output | 5 | One-hot acknowledge of the granted source |
| vector_o | output | 16 | Handler address of the last grant |

## Verification
A wrong in-service flag shows at the first boundary after the faulty update. Either a grant appears where R8 or R9 forbid one, or a legal preemption or re-entry is missing. A wrong return decode (R10) is caught by the case where two levels are nested: after a single return, a low request must still be refused. Ordering and mask faults show as the wrong `ack_o` bit or wrong address in the grant cycle itself. Each pattern is therefore checked one clock after its boundary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   localparam int unsigned SRC_N_DEF      = 5;
   localparam int unsigned CFG_W_DEF      = 8;
   localparam int unsigned VEC_W_DEF      = 16;
   localparam int unsigned VEC_BASE_DEF   = 3;
   localparam int unsigned VEC_STRIDE_DEF = 8;

   // Level selector for the in-service tracker
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } lvl_e;

   // Handler address of a source index
   function automatic logic [31:0] vec_addr(input int unsigned idx,
                                            input int unsigned base,
                                            input int unsigned stride);
      return 32'(base + idx * stride);
   endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int unsigned SRC_N = 5,
   parameter int unsigned CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_we_i,
   input  logic             level_we_i,
   input  logic [CFG_W-1:0] wdata_i,
   output logic [SRC_N-1:0] src_en_o,
   output logic             glb_en_o,
   output logic [SRC_N-1:0] src_hi_o
);

   localparam int unsigned GLB_BIT = CFG_W - 1;

   initial begin
      if (SRC_N < 1) $error("irq_cfg_regs: SRC_N must be at least 1");
      if (SRC_N >= CFG_W) $error("irq_cfg_regs: CFG_W must leave room for the master bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_en_o <= '0;
         glb_en_o <= 1'b0;
      end else if (mask_we_i) begin
         src_en_o <= wdata_i[SRC_N-1:0];
         glb_en_o <= wdata_i[GLB_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_hi_o <= '0;
      else if (level_we_i) src_hi_o <= wdata_i[SRC_N-1:0];
   end

   // Bits between the source field and the master bit carry no function
   generate
      if (GLB_BIT > SRC_N) begin : g_spare
         logic unused_spare_bits;
         assign unused_spare_bits = ^wdata_i[GLB_BIT-1:SRC_N];
      end
   endgenerate

   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i |=> (glb_en_o == $past(wdata_i[GLB_BIT]))); // R2

endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
   parameter int unsigned W = 5
) (
   input  logic [W-1:0] vec_i,
   output logic [W-1:0] grant_o,
   output logic         hit_o
);

   logic [W:0] seen;
   assign seen[0] = 1'b0;

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_chain
         assign grant_o[i]  = vec_i[i] & ~seen[i];
         assign seen[i+1]   = seen[i] | vec_i[i];
      end
   endgenerate

   assign hit_o = seen[W];

   always_comb begin
      AST_GRANT_ONEHOT: assert ($onehot0(grant_o)); // R6
   end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
   input  logic clk,
   input  logic rst_n,
   input  logic accept_i,
   input  logic accept_hi_i,
   input  logic reti_i,
   output logic svc_hi_o,
   output logic svc_lo_o
);

   import irq_arb_pkg::*;

   logic hi_nxt, lo_nxt;
   lvl_e acc_lvl;

   assign acc_lvl = accept_hi_i ? LVL_HIGH : LVL_LOW;

   always_comb begin
      hi_nxt = svc_hi_o;
      lo_nxt = svc_lo_o;
      if (reti_i) begin
         if (svc_hi_o) hi_nxt = 1'b0;
         else          lo_nxt = 1'b0;
      end
      if (accept_i) begin
         if (acc_lvl == LVL_HIGH) hi_nxt = 1'b1;
         else                     lo_nxt = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_hi_o <= 1'b0;
         svc_lo_o <= 1'b0;
      end else begin
         svc_hi_o <= hi_nxt;
         svc_lo_o <= lo_nxt;
      end
   end

   AST_HIGH_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
      svc_hi_o |-> !accept_i); // R9

   AST_LOW_ONLY_BY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_lo_o && accept_i) |-> accept_hi_i); // R8

   AST_RETI_DROPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && svc_hi_o && !accept_i) |=> (!svc_hi_o && $stable(svc_lo_o))); // R10

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned SRC_N      = irq_arb_pkg::SRC_N_DEF,
   parameter int unsigned CFG_W      = irq_arb_pkg::CFG_W_DEF,
   parameter int unsigned VEC_W      = irq_arb_pkg::VEC_W_DEF,
   parameter int unsigned VEC_BASE   = irq_arb_pkg::VEC_BASE_DEF,
   parameter int unsigned VEC_STRIDE = irq_arb_pkg::VEC_STRIDE_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_we_i,
   input  logic             level_we_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   input  logic [SRC_N-1:0] req_i,
   input  logic             boundary_i,
   input  logic             reti_i,
   output logic             take_o,
   output logic [SRC_N-1:0] ack_o,
   output logic [VEC_W-1:0] vector_o
);

   import irq_arb_pkg::*;

   localparam int unsigned LAST_VEC = VEC_BASE + (SRC_N - 1) * VEC_STRIDE;

   initial begin
      if (VEC_W > 32) $error("irq_arbiter: VEC_W above 32 is not supported");
      if (VEC_W < 32 && LAST_VEC >= (32'd1 << VEC_W))
         $error("irq_arbiter: VEC_W too narrow for the highest handler address");
   end

   logic [SRC_N-1:0] src_en, src_hi;
   logic             glb_en;
   logic             svc_hi, svc_lo;

   irq_cfg_regs #(.SRC_N(SRC_N), .CFG_W(CFG_W)) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we_i  (mask_we_i),
      .level_we_i (level_we_i),
      .wdata_i    (cfg_wdata_i),
      .src_en_o   (src_en),
      .glb_en_o   (glb_en),
      .src_hi_o   (src_hi)
   );

   // Eligible requests split by level
   logic [SRC_N-1:0] cand, cand_hi, cand_lo;
   assign cand    = req_i & src_en & {SRC_N{glb_en}};
   assign cand_hi = cand & src_hi;
   assign cand_lo = cand & ~src_hi;

   logic [SRC_N-1:0] gnt_hi, gnt_lo;
   logic             hit_hi, hit_lo;

   irq_first_set #(.W(SRC_N)) pick_hi_i (.vec_i(cand_hi), .grant_o(gnt_hi), .hit_o(hit_hi));
   irq_first_set #(.W(SRC_N)) pick_lo_i (.vec_i(cand_lo), .grant_o(gnt_lo), .hit_o(hit_lo));

   logic allow_hi, allow_lo, win_hi, win_lo, accept;
   assign allow_hi = boundary_i & ~svc_hi;
   assign allow_lo = boundary_i & ~svc_hi & ~svc_lo;
   assign win_hi   = allow_hi & hit_hi;
   assign win_lo   = allow_lo & hit_lo & ~win_hi;
   assign accept   = win_hi | win_lo;

   logic [SRC_N-1:0] grant;
   assign grant = win_hi ? gnt_hi : (win_lo ? gnt_lo : '0);

   irq_svc_track svc_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .accept_hi_i (win_hi),
      .reti_i      (reti_i),
      .svc_hi_o    (svc_hi),
      .svc_lo_o    (svc_lo)
   );

   // Handler address from the one-hot grant
   logic [VEC_W-1:0] vec_nxt;
   always_comb begin
      vec_nxt = '0;
      for (int i = 0; i < SRC_N; i++) begin
         if (grant[i])
            vec_nxt = vec_nxt | VEC_W'(vec_addr(i, VEC_BASE, VEC_STRIDE));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o   <= 1'b0;
         ack_o    <= '0;
         vector_o <= '0;
      end else begin
         take_o <= accept;
         ack_o  <= grant;
         if (accept) vector_o <= vec_nxt;
      end
   end

   AST_ACK_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> ($countones(ack_o) == 1)); // R5

   AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> (ack_o == '0)); // R5

   AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(boundary_i)); // R5

   AST_TAKE_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(glb_en)); // R2

   AST_ACK_WAS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> ((ack_o & ~$past(src_en)) == '0)); // R3

endmodule

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mask_we = 1'b0, level_we = 1'b0;
   logic [7:0] wdata = '0;
   logic [4:0] req = '0;
   logic       bnd = 1'b0, reti = 1'b0;
   logic       take;
   logic [4:0] ack;
   logic [15:0] vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .mask_we_i(mask_we), .level_we_i(level_we),
      .cfg_wdata_i(wdata), .req_i(req), .boundary_i(bnd), .reti_i(reti),
      .take_o(take), .ack_o(ack), .vector_o(vec)
   );

   // Scoreboard queues
   bit        q_take[$];
   int        q_idx[$];
   string     q_tag[$];

   always @(negedge clk) begin
      if (q_take.size() > 0) begin
         bit    et;
         int    ei;
         string tg;
         et = q_take.pop_front();
         ei = q_idx.pop_front();
         tg = q_tag.pop_front();
         checks++;
         if (take !== et) begin
            errors++;
            $display("FAIL %s: take actual %0b expected %0b", tg, take, et);
         end else if (et) begin
            if (ack !== (5'd1 << ei) || vec !== 16'(3 + 8 * ei)) begin
               errors++;
               $display("FAIL %s: ack/vector actual %b/%h expected %b/%h",
                        tg, ack, vec, 5'd1 << ei, 16'(3 + 8 * ei));
            end
         end else if (ack !== 5'd0) begin
            errors++;
            $display("FAIL %s: ack actual %b expected 00000", tg, ack);
         end
      end
   end

   // One cycle of stimulus; expectation is pushed after the edge
   task automatic cyc(input logic [4:0] r, input logic b, input logic rt,
                      input bit et, input int ei, input string tg);
      @(negedge clk);
      req = r; bnd = b; reti = rt;
      @(posedge clk);
      #1;
      q_take.push_back(et); q_idx.push_back(ei); q_tag.push_back(tg);
   endtask

   task automatic wr(input bit is_level, input logic [7:0] d);
      @(negedge clk);
      bnd = 1'b0; reti = 1'b0; wdata = d;
      mask_we = !is_level; level_we = is_level;
      @(negedge clk);
      mask_we = 1'b0; level_we = 1'b0;
   endtask

   task automatic ret();
      cyc(5'h00, 1'b0, 1'b1, 1'b0, 0, "R10 return cycle");
      @(negedge clk); reti = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      req = 5'h1F; bnd = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset leaves everything masked
      cyc(5'h1F, 1'b1, 1'b0, 1'b0, 0, "R1 masked after reset");
      cyc(5'h1F, 1'b1, 1'b0, 1'b0, 0, "R1 masked after reset");
      // R2: source bits set, master off
      wr(1'b0, 8'h1F);
      cyc(5'h1F, 1'b1, 1'b0, 1'b0, 0, "R2 master enable off");
      // master on, all low priority
      wr(1'b0, 8'h9F);
      cyc(5'h1F, 1'b0, 1'b0, 1'b0, 0, "R5 no boundary");
      cyc(5'h1F, 1'b1, 1'b0, 1'b1, 0, "R6 R4 ext0 first");
      cyc(5'h1E, 1'b1, 1'b0, 1'b0, 0, "R8 low blocks low");
      ret();
      cyc(5'h1E, 1'b1, 1'b0, 1'b1, 1, "R10 R4 timer0 after return");
      ret();
      cyc(5'h1C, 1'b1, 1'b0, 1'b1, 2, "R4 ext1 vector");
      ret();
      cyc(5'h18, 1'b1, 1'b0, 1'b1, 3, "R4 timer1 vector");
      ret();
      cyc(5'h10, 1'b1, 1'b0, 1'b1, 4, "R4 serial vector");
      ret();
      // R11/R7: serial high
      wr(1'b1, 8'h10);
      cyc(5'h1F, 1'b1, 1'b0, 1'b1, 4, "R7 R11 high over low");
      cyc(5'h1F, 1'b1, 1'b0, 1'b0, 0, "R9 high blocks all");
      ret();
      cyc(5'h0F, 1'b1, 1'b0, 1'b1, 0, "R6 low ext0 taken");
      cyc(5'h1F, 1'b1, 1'b0, 1'b1, 4, "R8 high preempts low");
      cyc(5'h1F, 1'b1, 1'b0, 1'b0, 0, "R9 nested high blocks");
      ret();
      cyc(5'h0F, 1'b1, 1'b0, 1'b0, 0, "R10 low still in service");
      ret();
      cyc(5'h0F, 1'b1, 1'b0, 1'b1, 0, "R10 low released");
      ret();
      // R3: ext0 masked
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h9E);
      cyc(5'h01, 1'b1, 1'b0, 1'b0, 0, "R3 masked source ignored");
      cyc(5'h03, 1'b1, 1'b0, 1'b1, 1, "R3 next enabled source");
      ret();
      // R11: two high sources tie by index
      wr(1'b0, 8'h9F);
      wr(1'b1, 8'h0A);
      cyc(5'h1F, 1'b1, 1'b0, 1'b1, 1, "R11 R6 lowest high index");
      ret();
      // R2: master off again
      wr(1'b0, 8'h1F);
      cyc(5'h1F, 1'b1, 1'b0, 1'b0, 0, "R2 master cleared");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule